// File: doc/BRIEF.md
# Pretrigger Circular Capture Buffer

This block stores the rows of a logic capture in RAM. A row is the timestamp placed above the channel data word. A row is written whenever an event strobe or a timestamp-rollover strobe pulses. An arm pulse starts a capture and latches the pre-capture row count. Until the trigger is seen, rows are written into a circular region at the bottom of the memory, and that region is sized by the latched count. The oldest rows in it are overwritten.

When the triggered flag goes high, the circular region is frozen. Rows are then appended into the rest of the memory in order, and the full flag rises when the top row has been written. After that, a read handshake returns the captured rows one at a time. The pre-trigger rows come first, starting from the oldest surviving one, and the post-trigger rows follow. Each returned row carries a flag that tells whether it was captured before the trigger, and the final row is marked.

Top module: `pretrig_capture_buf`

## Requirements
- R1: After reset, full_o and rd_valid_o are 0 and the block ignores strobes until the first arm_i pulse.
- R2: A row is written when event_i or rollover_i, or both, are high on a clock edge. The row is {ts_i, data_i}, and it is returned on readout as rd_ts_o and rd_data_o.
- R3: arm_i latches pre_rows_i as the circular region size P and clears any earlier capture. Before the trigger, writes go to rows 0..P-1 in order and wrap back to row 0. Once the region has wrapped, readout returns exactly P pre-trigger rows, oldest first.
- R4: If the trigger comes before P rows have been written, readout returns only the N rows actually written, as pre-trigger rows, in write order starting at row 0.
- R5: After the trigger, DEPTH-P rows are appended. full_o rises on the clock edge that writes the last of them and stays high until the next arm_i.
- R6: While full_o is high and rows remain, rd_req_i high on an edge makes rd_valid_o high for one cycle after that edge, with the next row. rd_valid_o never rises when full_o was low.
- R7: rd_pre_o is 1 for pre-trigger rows and 0 for post-trigger rows. rd_last_o is 1 on the final row only. Any request after the final row gives no rd_valid_o.
- R8: Strobes while full_o is high do not change the stored rows.
- R9: A strobe on the first edge at which triggered_i is high is stored as the first post-trigger row.
- R10: A pre_rows_i value of 0 is treated as P = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Start a new capture and latch pre_rows_i |
| event_i | input | 1 | Event write strobe |
| rollover_i | input | 1 | Timestamp rollover write strobe |
| data_i | input | DATA_W | Channel data word |
| ts_i | input | TS_W | Relative timestamp |
| triggered_i | input | 1 | Trigger has occurred (level) |
| pre_rows_i | input | log2(DEPTH) | Pre-capture row count |
| full_o | output | 1 | Capture complete, readout allowed |
| rd_req_i | input | 1 | Request the next row |
| rd_valid_o | output | 1 | Row outputs valid this cycle |
| rd_data_o | output | DATA_W | Channel data of the returned row |
| rd_ts_o | output | TS_W | Timestamp of the returned row |
| rd_pre_o | output | 1 | Returned row is from before the trigger |
| rd_last_o | output | 1 | Returned row is the final one |

## Verification
The bench keeps its own model of the last P pre-trigger rows and the post-trigger list. It compares every returned row against that model, over region sizes that wrap, that never fill, that are clamped from 0, and that leave a single post row. Each of these faults shows up against the model. If the readout does not start at the write pointer after a wrap, the rows come back rotated. If an unwrapped region is read as full, stale rows appear. If the row written on the trigger edge is placed wrongly, that row lands in the pre-trigger data. If writes are not locked out after full, rows that were already captured are corrupted. The bench also checks the exact edge on which full_o rises, and it checks that a request after the final row returns nothing.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE,
    CAP_PRE,
    CAP_POST,
    CAP_FULL
  } cap_state_e;
endpackage

// File: rtl/cap_ram.sv
module cap_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/cap_wr_ctrl.sv
module cap_wr_ctrl
  import cap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          strobe_i,
  input  logic          triggered_i,
  input  logic [AW-1:0] pre_rows_i,
  output cap_state_e    state_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] wptr_o,
  output logic          wrapped_o,
  output logic [AW-1:0] pre_size_o
);
  localparam logic [AW-1:0] TOP_ROW = AW'(DEPTH - 1);

  cap_state_e    state_q;
  logic [AW-1:0] wptr_q, pptr_q, psz_q, psz_clamped;
  logic          wrapped_q, post_now, active;

  assign psz_clamped = (pre_rows_i == '0) ? AW'(1) : pre_rows_i;
  assign active      = (state_q == CAP_PRE) || (state_q == CAP_POST);
  assign post_now    = (state_q == CAP_POST) || ((state_q == CAP_PRE) && triggered_i);
  assign we_o        = strobe_i && active;
  assign waddr_o     = post_now ? pptr_q : wptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= CAP_IDLE;
      wptr_q    <= '0;
      pptr_q    <= '0;
      psz_q     <= AW'(1);
      wrapped_q <= 1'b0;
    end else if (arm_i) begin
      state_q   <= CAP_PRE;
      wptr_q    <= '0;
      wrapped_q <= 1'b0;
      psz_q     <= psz_clamped;
      pptr_q    <= psz_clamped;
    end else if (post_now) begin
      // trigger edge or later: region frozen, linear append
      state_q <= CAP_POST;
      if (strobe_i) begin
        pptr_q <= pptr_q + AW'(1);
        if (pptr_q == TOP_ROW) state_q <= CAP_FULL;
      end
    end else if (state_q == CAP_PRE && strobe_i) begin
      if (wptr_q == psz_q - AW'(1)) begin
        wptr_q    <= '0;
        wrapped_q <= 1'b1;
      end else begin
        wptr_q <= wptr_q + AW'(1);
      end
    end
  end

  assign state_o    = state_q;
  assign wptr_o     = wptr_q;
  assign wrapped_o  = wrapped_q;
  assign pre_size_o = psz_q;
endmodule

// File: rtl/cap_rd_ctrl.sv
module cap_rd_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          full_i,
  input  logic          rd_req_i,
  input  logic [AW-1:0] pre_size_i,
  input  logic [AW-1:0] wptr_i,
  input  logic          wrapped_i,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic          rd_valid_o,
  output logic          rd_pre_o,
  output logic          rd_last_o
);
  logic [CW-1:0] ridx_q, pre_cnt, total, psz_w, oldest, circ, circ_wr, lin;
  logic          in_pre, fire;

  assign psz_w   = {1'b0, pre_size_i};
  assign pre_cnt = wrapped_i ? psz_w : {1'b0, wptr_i};
  assign oldest  = wrapped_i ? {1'b0, wptr_i} : '0;
  assign total   = CW'(DEPTH) - psz_w + pre_cnt;
  assign in_pre  = ridx_q < pre_cnt;
  assign circ    = oldest + ridx_q;
  assign circ_wr = (circ >= psz_w) ? circ - psz_w : circ;
  assign lin     = psz_w + ridx_q - pre_cnt;
  assign fire    = full_i && rd_req_i && !arm_i && (ridx_q < total);
  assign re_o    = fire;
  assign raddr_o = in_pre ? circ_wr[AW-1:0] : lin[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ridx_q     <= '0;
      rd_valid_o <= 1'b0;
      rd_pre_o   <= 1'b0;
      rd_last_o  <= 1'b0;
    end else if (arm_i) begin
      ridx_q     <= '0;
      rd_valid_o <= 1'b0;
      rd_last_o  <= 1'b0;
    end else begin
      rd_valid_o <= fire;
      if (fire) begin
        ridx_q    <= ridx_q + CW'(1);
        rd_pre_o  <= in_pre;
        rd_last_o <= (ridx_q == total - CW'(1));
      end
    end
  end
endmodule

// File: rtl/pretrig_capture_buf.sv
module pretrig_capture_buf
  import cap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TS_W   = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int ROW_W = TS_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              event_i,
  input  logic              rollover_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic              triggered_i,
  input  logic [AW-1:0]     pre_rows_i,
  output logic              full_o,
  input  logic              rd_req_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [TS_W-1:0]   rd_ts_o,
  output logic              rd_pre_o,
  output logic              rd_last_o
);
  cap_state_e    state;
  logic          we, re, wrapped;
  logic [AW-1:0] waddr, raddr, wptr, psz;
  logic [ROW_W-1:0] rdata;

  cap_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm_i),
    .strobe_i    (event_i | rollover_i),
    .triggered_i (triggered_i),
    .pre_rows_i  (pre_rows_i),
    .state_o     (state),
    .we_o        (we),
    .waddr_o     (waddr),
    .wptr_o      (wptr),
    .wrapped_o   (wrapped),
    .pre_size_o  (psz)
  );

  assign full_o = (state == CAP_FULL);

  cap_ram #(.W(ROW_W), .DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i ({ts_i, data_i}),
    .re_i    (re),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  cap_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm_i),
    .full_i     (full_o),
    .rd_req_i   (rd_req_i),
    .pre_size_i (psz),
    .wptr_i     (wptr),
    .wrapped_i  (wrapped),
    .re_o       (re),
    .raddr_o    (raddr),
    .rd_valid_o (rd_valid_o),
    .rd_pre_o   (rd_pre_o),
    .rd_last_o  (rd_last_o)
  );

  assign {rd_ts_o, rd_data_o} = rdata;
endmodule

// File: rtl/pretrig_capture_buf_chk.sv
module pretrig_capture_buf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic arm_i,
  input logic event_i,
  input logic rollover_i,
  input logic full_o,
  input logic rd_req_i,
  input logic rd_valid_o,
  input logic rd_pre_o,
  input logic rd_last_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_VALID_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && rd_valid_o |-> $past(rd_req_i) && $past(full_o)); // R6
  AST_NO_VALID_UNFULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_o |=> !rd_valid_o); // R6
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !arm_i |=> full_o); // R5
  AST_FULL_RISE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $rose(full_o) |-> $past(event_i || rollover_i)); // R5
  AST_NOTHING_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && rd_last_o |=> !rd_valid_o); // R7
  AST_POST_NOT_BEFORE_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_pre_o && !arm_i |=> !(rd_valid_o && rd_pre_o)); // R7
endmodule

bind pretrig_capture_buf pretrig_capture_buf_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .arm_i      (arm_i),
  .event_i    (event_i),
  .rollover_i (rollover_i),
  .full_o     (full_o),
  .rd_req_i   (rd_req_i),
  .rd_valid_o (rd_valid_o),
  .rd_pre_o   (rd_pre_o),
  .rd_last_o  (rd_last_o)
);

// File: tb/pretrig_capture_buf_test.sv
`timescale 1ns/100ps
module pretrig_capture_buf_test;
  localparam int DATA_W = 8;
  localparam int TS_W   = 8;
  localparam int DEPTH  = 16;
  localparam int AW     = $clog2(DEPTH);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic arm_i = 1'b0, event_i = 1'b0, rollover_i = 1'b0, triggered_i = 1'b0, rd_req_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic [TS_W-1:0]   ts_i = '0;
  logic [AW-1:0]     pre_rows_i = '0;
  logic full_o, rd_valid_o, rd_pre_o, rd_last_o;
  logic [DATA_W-1:0] rd_data_o;
  logic [TS_W-1:0]   rd_ts_o;

  int errors = 0, checks = 0;
  logic [15:0] pre_q[$];
  logic [15:0] post_q[$];

  always #2.5 clk_i = ~clk_i;

  pretrig_capture_buf #(.DATA_W(DATA_W), .TS_W(TS_W), .DEPTH(DEPTH)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff_size(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  task automatic arm(input int p);
    arm_i = 1'b1; pre_rows_i = AW'(p); triggered_i = 1'b0;
    @(negedge clk_i);
    arm_i = 1'b0;
    pre_q.delete(); post_q.delete();
  endtask

  // one strobe; returns stored row value
  task automatic put_row(output logic [15:0] row);
    int k = $urandom % 3;
    data_i = DATA_W'($urandom); ts_i = TS_W'($urandom);
    event_i = (k != 1); rollover_i = (k != 0); // R2: either or both
    row = {ts_i, data_i};
    @(negedge clk_i);
    event_i = 1'b0; rollover_i = 1'b0;
  endtask

  task automatic capture(input int p, input int npre, input bit trig_with_row);
    logic [15:0] row;
    int psz = eff_size(p);
    int npost = DEPTH - psz;
    arm(p);
    for (int i = 0; i < npre; i++) begin
      put_row(row);
      pre_q.push_back(row);
      if (pre_q.size() > psz) void'(pre_q.pop_front()); // R3 circular
    end
    triggered_i = 1'b1;
    if (!trig_with_row) @(negedge clk_i);
    for (int i = 0; i < npost; i++) begin
      chk("R5 full before last", full_o, 0);
      put_row(row); // R9: first of these may share the trigger edge
      post_q.push_back(row);
    end
    chk("R5 full after last", full_o, 1);
    for (int i = 0; i < 3; i++) put_row(row); // R8 ignored
    triggered_i = 1'b0;
    chk("R5 full held", full_o, 1);
  endtask

  task automatic readout();
    int n = pre_q.size() + post_q.size();
    for (int i = 0; i < n; i++) begin
      logic [15:0] exp;
      bit is_pre = (i < pre_q.size());
      exp = is_pre ? pre_q[i] : post_q[i - pre_q.size()];
      rd_req_i = 1'b1;
      @(negedge clk_i);
      rd_req_i = 1'b0;
      chk("R6 valid", rd_valid_o, 1);
      chk(is_pre ? "R3/R4 pre row" : "R8/R9 post row", {rd_ts_o, rd_data_o}, exp);
      chk("R7 pre flag", rd_pre_o, is_pre);
      chk("R7 last flag", rd_last_o, (i == n - 1));
      @(negedge clk_i);
      chk("R6 single pulse", rd_valid_o, 0);
    end
    rd_req_i = 1'b1;
    @(negedge clk_i);
    rd_req_i = 1'b0;
    chk("R7 no row after last", rd_valid_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] row;
    void'($urandom(32'd11));
    repeat (3) @(negedge clk_i);
    chk("R1 full reset", full_o, 0);
    chk("R1 valid reset", rd_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    put_row(row);
    rd_req_i = 1'b1; triggered_i = 1'b1;
    @(negedge clk_i);
    rd_req_i = 1'b0; triggered_i = 1'b0;
    chk("R1 idle ignores strobes", full_o, 0);
    chk("R1 idle no read", rd_valid_o, 0);

    capture(5, 12, 1'b1);  readout();  // R3 wrapped, R9 trigger with row
    capture(6, 3, 1'b0);   readout();  // R4 not wrapped
    capture(4, 4, 1'b0);   readout();  // R3 exact fill
    capture(0, 4, 1'b1);   readout();  // R10 clamp to 1
    capture(15, 0, 1'b0);  readout();  // R4 empty pre, single post row
    for (int t = 0; t < 8; t++) begin
      capture(1 + ($urandom % 15), $urandom % 31, 1'($urandom));
      readout();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule